// File: doc/BRIEF.md
# Byte-Addressed Serial Memory Target with Gated Page Writes

This block is the two-wire bus target of a small identification memory. Once the mode controller of the chip raises its enable, the block listens for a START condition. It accepts only the fixed seven-bit device identifier `1010000`, and it gives byte-level read and write access to a 256 x 8 storage array. The array sits outside the block and is reached through a combinational read port and a one-cycle write strobe.

Write data is collected in an eight-slot page buffer. Nothing reaches the array until the master sends STOP, and then only if the write-protect input is low and the slow-clock input is high at that moment. An accepted page is flushed to the array one slot per clock. A cycle counter then models the self-timed program interval. During that interval the target refuses its own address, so the master can poll for completion. Each acknowledged matching address byte also sends a one-cycle pulse to the mode controller.

The state machine has these states:

- `S_IDLE`: waits for START.
- `S_DEV`: receives the device byte.
- `S_DACK`: acknowledges a matching device byte.
- `S_WADDR`: receives the word address.
- `S_AACK`: acknowledges the word address.
- `S_WDATA`: receives a data byte.
- `S_WACK`: acknowledges a data byte.
- `S_RDATA`: transmits a data byte.
- `S_RACK`: samples the master's acknowledge.
- `S_COMMIT`: flushes the page buffer.

The transitions are:

- START goes to `S_DEV` from every state except `S_COMMIT`.
- STOP goes to `S_COMMIT` from `S_WDATA` when the commit is allowed. Otherwise STOP goes to `S_IDLE`.
- `S_DEV` goes to `S_DACK` on a match, or to `S_IDLE` on a miss.
- `S_DACK` goes to `S_RDATA` for a read, or to `S_WADDR` for a write.
- `S_WADDR` goes to `S_AACK`, and `S_AACK` goes to `S_WDATA`.
- `S_WDATA` and `S_WACK` alternate.
- `S_RDATA` goes to `S_RACK`.
- `S_RACK` goes to `S_RDATA` when the master acknowledges, or to `S_IDLE` when it does not.
- `S_COMMIT` goes to `S_IDLE` after eight cycles.
- Dropping the enable forces `S_IDLE`, except in `S_COMMIT`.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A device byte whose upper seven bits equal 1010000 is acknowledged by pulling SDA low in the ninth clock, and `match_o` is high for exactly one clock at that point. Any other identifier gets no acknowledge and no pulse. Bit 0 of the device byte selects a read when it is 1.
- R2: While `mode_en_i` is low, the block never drives SDA and never pulses `match_o`.
- R3: In a write, the byte after the device byte is the word address, and every following byte is a data byte. Each of these bytes is acknowledged.
- R4: Data bytes land in the page buffer at column (word address + n) mod 8, staying inside the 8-byte page that contains the word address. A later byte in the same column replaces the earlier one. Array locations whose column received no byte are not written.
- R5: The buffered page is written to the array only at STOP, and only if `wp_i` is 0 and `vclk_i` is 1 at that moment. Otherwise the page is discarded and no busy interval starts.
- R6: After a committed page, for `WR_CYCLES` clocks the device byte is not acknowledged, no `match_o` pulse is given, and no array write happens. After that interval the device byte is acknowledged again.
- R7: A read returns bytes starting at the current word address, most significant bit first. The address increments after each byte and wraps from FFh to 00h. A master that does not acknowledge ends the read.
- R8: After reset, `sda_oe_o`, `match_o` and `mem_we_o` are all 0.
- R9: A START (repeated START) that arrives while write data is buffered discards that data, and no busy interval follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| wp_i | input | 1 | Write-protect; 1 blocks commits |
| vclk_i | input | 1 | Slow-clock pin level; must be 1 to commit |
| mode_en_i | input | 1 | Bus target enable from the mode controller |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| match_o | output | 1 | One-cycle pulse on an acknowledged matching device byte |
| mem_raddr_o | output | 8 | Array read address |
| mem_rdata_i | input | 8 | Array read data, combinational from `mem_raddr_o` |
| mem_we_o | output | 1 | Array write strobe |
| mem_waddr_o | output | 8 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The assertions assume the following about the inputs:

- `scl_i` and `sda_i` are already synchronized and free of glitches.
- SDA changes only while SCL is low, except for START and STOP.
- Each SCL phase lasts several block clocks, so the registered drive settles before the next edge.
- `mode_en_i` does not toggle in the middle of a transaction.

The bench keeps within these assumptions. It builds every bus phase from ten-clock half periods and changes its SDA level only after lowering SCL. It changes the enable, protect and slow-clock levels only between transactions, while the bus is idle.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
    localparam int AW = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DACK,
        S_WADDR,
        S_AACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_RACK,
        S_COMMIT
    } state_t;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/page_buf.sv
module page_buf #(
    parameter int PAGE_BYTES = 8,
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  wr_i,
    input  logic [PW-1:0]         widx_i,
    input  logic [7:0]            wdata_i,
    input  logic [PW-1:0]         ridx_i,
    output logic [7:0]            rdata_o,
    output logic [PAGE_BYTES-1:0] valid_o
);
    logic [7:0] slot_q  [PAGE_BYTES];
    logic       valid_q [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[i]  <= '0;
                valid_q[i] <= 1'b0;
            end else if (clr_i) begin
                valid_q[i] <= 1'b0;
            end else if (wr_i && widx_i == PW'(i)) begin
                slot_q[i]  <= wdata_i;
                valid_q[i] <= 1'b1;
            end
        end
        assign valid_o[i] = valid_q[i];
    end

    assign rdata_o = slot_q[ridx_i];
endmodule

// File: rtl/wr_timer.sv
module wr_timer #(
    parameter int WR_CYCLES = 1000,
    localparam int CW = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= CW'(WR_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eeprom_i2c_pkg::*;
#(
    parameter int         PAGE_BYTES = 8,
    parameter int         WR_CYCLES  = 1000,
    parameter logic [6:0] DEV_ID     = 7'b1010000,
    localparam int        PW         = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          wp_i,
    input  logic          vclk_i,
    input  logic          mode_en_i,
    output logic          sda_oe_o,
    output logic          match_o,
    output logic [AW-1:0] mem_raddr_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_waddr_o,
    output logic [7:0]    mem_wdata_o
);
    logic scl_rise, scl_fall, bus_start, bus_stop;
    state_t state, state_d;
    logic [3:0] bitcnt;
    logic [7:0] shreg, txreg;
    logic [AW-1:0] ptr;
    logic [PW-1:0] col, cidx;
    logic rw_rd, mack;
    logic tmr_busy, wr_busy, dev_ok, commit_ok;
    logic pb_clr, pb_wr;
    logic [7:0] pb_rdata;
    logic [PAGE_BYTES-1:0] pb_valid;
    logic [2:0] tx_idx;

    i2c_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(bus_start), .stop_o(bus_stop)
    );

    page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
        .clk(clk), .rst_n(rst_n), .clr_i(pb_clr), .wr_i(pb_wr),
        .widx_i(col), .wdata_i(shreg), .ridx_i(cidx),
        .rdata_o(pb_rdata), .valid_o(pb_valid)
    );

    wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start_i(state == S_COMMIT && cidx == PW'(PAGE_BYTES - 1)),
        .busy_o(tmr_busy)
    );

    assign wr_busy   = tmr_busy | (state == S_COMMIT);
    assign dev_ok    = (shreg[7:1] == DEV_ID) && !wr_busy;
    assign commit_ok = (state == S_WDATA) && (|pb_valid) && !wp_i && vclk_i;
    assign tx_idx    = 3'(4'd7 - bitcnt);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state;
        if (state == S_COMMIT) begin
            if (cidx == PW'(PAGE_BYTES - 1)) state_d = S_IDLE;
        end else if (!mode_en_i) begin
            state_d = S_IDLE;
        end else if (bus_stop) begin
            state_d = commit_ok ? S_COMMIT : S_IDLE;
        end else if (bus_start) begin
            state_d = S_DEV;
        end else if (scl_fall) begin
            unique case (state)
                S_DEV:   if (bitcnt == 4'd8) state_d = dev_ok ? S_DACK : S_IDLE;
                S_DACK:  state_d = rw_rd ? S_RDATA : S_WADDR;
                S_WADDR: if (bitcnt == 4'd8) state_d = S_AACK;
                S_AACK:  state_d = S_WDATA;
                S_WDATA: if (bitcnt == 4'd8) state_d = S_WACK;
                S_WACK:  state_d = S_WDATA;
                S_RDATA: if (bitcnt == 4'd8) state_d = S_RACK;
                S_RACK:  state_d = mack ? S_RDATA : S_IDLE;
                default: state_d = state;
            endcase
        end
    end

    assign pb_clr = (state == S_WADDR) && (state_d == S_AACK);
    assign pb_wr  = (state == S_WDATA) && (state_d == S_WACK);

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            txreg    <= '0;
            ptr      <= '0;
            col      <= '0;
            cidx     <= '0;
            rw_rd    <= 1'b0;
            mack     <= 1'b0;
            sda_oe_o <= 1'b0;
            match_o  <= 1'b0;
        end else begin
            match_o <= 1'b0;
            if (scl_rise && (state == S_DEV || state == S_WADDR ||
                             state == S_WDATA || state == S_RDATA)) begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[6:0], sda_i};
            end
            if (scl_rise && state == S_RACK) mack <= !sda_i;
            if (state == S_COMMIT) cidx <= cidx + 1'b1;
            if (state_d != state || bus_start) begin
                unique case (state_d)
                    S_DEV, S_WADDR, S_WDATA: begin
                        bitcnt   <= '0;
                        sda_oe_o <= 1'b0;
                    end
                    S_DACK: begin
                        sda_oe_o <= 1'b1;
                        match_o  <= 1'b1;
                        rw_rd    <= shreg[0];
                    end
                    S_AACK: begin
                        sda_oe_o <= 1'b1;
                        ptr      <= shreg;
                        col      <= shreg[PW-1:0];
                    end
                    S_WACK: begin
                        sda_oe_o <= 1'b1;
                        col      <= col + 1'b1;
                    end
                    S_RDATA: begin
                        bitcnt   <= '0;
                        txreg    <= mem_rdata_i;
                        sda_oe_o <= !mem_rdata_i[7];
                    end
                    S_RACK: begin
                        sda_oe_o <= 1'b0;
                        ptr      <= ptr + 1'b1;
                    end
                    S_COMMIT: begin
                        cidx     <= '0;
                        sda_oe_o <= 1'b0;
                    end
                    default: sda_oe_o <= 1'b0;
                endcase
            end else if (state == S_RDATA && scl_fall) begin
                sda_oe_o <= !txreg[tx_idx];
            end
        end
    end

    assign mem_raddr_o = ptr;
    assign mem_we_o    = (state == S_COMMIT) && pb_valid[cidx];
    assign mem_waddr_o = {ptr[AW-1:PW], cidx};
    assign mem_wdata_o = pb_rdata;
endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk #(
    parameter int AW = 8,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_en_i,
    input logic          sda_oe_o,
    input logic          match_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_waddr_o,
    input logic          wr_busy,
    input logic          tmr_busy,
    input logic          idle_i
);
    AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);                                     // R1
    AST_MATCH_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> sda_oe_o);                                     // R1
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en_i |=> (!sda_oe_o && !match_o));                   // R2
    AST_PAGE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |->
            (mem_waddr_o[AW-1:PW] == $past(mem_waddr_o[AW-1:PW]))); // R4
    AST_NO_MATCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> !match_o);                                     // R6
    AST_NO_WRITE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !mem_we_o);                                   // R6
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |-> !sda_oe_o);                                     // R8
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(.AW(eeprom_i2c_pkg::AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_en_i(mode_en_i), .sda_oe_o(sda_oe_o),
    .match_o(match_o), .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o),
    .wr_busy(wr_busy), .tmr_busy(tmr_busy),
    .idle_i(state == eeprom_i2c_pkg::S_IDLE)
);

// File: tb/test_eeprom_i2c_target.sv
`timescale 1ns/1ps
module test_eeprom_i2c_target;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wp = 1'b0, vclk = 1'b1, men = 1'b1;
    logic sda_oe, match, we;
    logic [7:0] raddr, rdata, waddr, wdata;
    logic sda_line;
    logic [7:0] mem [256];
    logic [7:0] rbuf [16];
    int nchk = 0, nfail = 0, nmatch = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rdata = mem[raddr];

    eeprom_i2c_target i_eeprom_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .wp_i(wp), .vclk_i(vclk), .mode_en_i(men), .sda_oe_o(sda_oe),
        .match_o(match), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
        .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    initial for (int a = 0; a < 256; a++) mem[a] = init_val(a);
    always @(posedge clk) if (we) mem[waddr] <= wdata;
    always @(posedge clk) if (match) nmatch <= nmatch + 1;

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        ack = !sda_line; tick(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_m = 1'b1; tick(H / 2);
            b[i] = sda_line; tick(H / 2);
            scl_m = 1'b0;
        end
        sda_m = !give_ack; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; sda_m = 1'b1;
    endtask

    task automatic write_page(input logic [7:0] a, input int n, input logic [7:0] d0);
        bit ack;
        bus_start();
        send_byte(8'hA0, ack); check("R3 dev ack", ack, 1);
        send_byte(a, ack);     check("R3 addr ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(8'(d0 + k), ack); check("R3 data ack", ack, 1);
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [7:0] a, input int n);
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(a, ack);
        bus_start();
        send_byte(8'hA1, ack); check("R1 read dev ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            rbuf[k] = b;
        end
        bus_stop();
    endtask

    task automatic poll(output bit ack);
        bus_start();
        send_byte(8'hA0, ack);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        bit ack;
        int m0;
        logic [7:0] exp_pg [8];
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check("R8 reset oe", sda_oe, 0);
        check("R8 reset match", match, 0);
        check("R8 reset we", we, 0);

        // R1 sweep of every identifier in write mode
        for (int id = 0; id < 128; id++) begin
            m0 = nmatch;
            bus_start();
            send_byte({7'(id), 1'b0}, ack);
            bus_stop();
            check($sformatf("R1 ack id %0d", id), ack, id == 8'h50);
            check($sformatf("R1 pulse id %0d", id), nmatch - m0, id == 8'h50);
        end

        // R3/R5 single write, R6 busy polling
        write_page(8'h10, 1, 8'h5A);
        m0 = nmatch;
        poll(ack);
        check("R6 busy nack", ack, 0);
        check("R6 busy no pulse", nmatch - m0, 0);
        tick(1100);
        poll(ack);
        check("R6 ack after interval", ack, 1);
        rand_read(8'h10, 2);
        check("R3 written byte", rbuf[0], 8'h5A);
        check("R4 neighbour untouched", rbuf[1], init_val(8'h11));

        // R4 page wrap with overwrite: 10 bytes from 1Ch
        write_page(8'h1C, 10, 8'h80);
        tick(1100);
        for (int c = 0; c < 8; c++) exp_pg[c] = init_val(8'h18 + c);
        for (int k = 0; k < 10; k++) exp_pg[(8'h1C + k) & 7] = 8'(8'h80 + k);
        rand_read(8'h18, 9);
        for (int c = 0; c < 8; c++) check("R4 page byte", rbuf[c], exp_pg[c]);
        check("R4 next page untouched", rbuf[8], init_val(8'h20));

        // R5 write-protect blocks
        wp = 1'b1;
        write_page(8'h40, 1, 8'h33);
        wp = 1'b0;
        poll(ack);
        check("R5 wp no busy", ack, 1);
        rand_read(8'h40, 1);
        check("R5 wp discard", rbuf[0], init_val(8'h40));

        // R5 low slow-clock blocks
        vclk = 1'b0;
        write_page(8'h41, 1, 8'h44);
        vclk = 1'b1;
        poll(ack);
        check("R5 vclk no busy", ack, 1);
        rand_read(8'h41, 1);
        check("R5 vclk discard", rbuf[0], init_val(8'h41));

        // R9 repeated START discards buffered data
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h50, ack);
        send_byte(8'h77, ack);
        bus_start();
        bus_stop();
        poll(ack);
        check("R9 no busy", ack, 1);
        rand_read(8'h50, 1);
        check("R9 discard", rbuf[0], init_val(8'h50));

        // R7 sequential read wraps FFh -> 00h
        rand_read(8'hFD, 5);
        for (int k = 0; k < 5; k++)
            check("R7 seq read", rbuf[k], init_val((8'hFD + k) & 255));

        // R2 disabled target stays silent
        men = 1'b0;
        tick(4);
        m0 = nmatch;
        poll(ack);
        check("R2 disabled nack", ack, 0);
        check("R2 disabled no pulse", nmatch - m0, 0);
        men = 1'b1;
        tick(4);
        poll(ack);
        check("R2 re-enabled ack", ack, 1);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule